// File: doc/BRIEF.md
# Multi-format pixel unpacker

The unpacker takes a stream of 32-bit memory words, each tagged with a 4-bit format code, and turns it into a stream of pixels in one common 32-bit layout. Alpha occupies byte 3, and the first colour channel, the second colour channel and the third colour channel occupy bytes 2, 1 and 0. RGB sources yield alpha, red, green and blue. Packed 4:2:2 sources yield alpha, Y, U and V. Formats of 16 bits per pixel carry two pixels in a word, and the low half is emitted first.

Both sides use a valid/ready handshake. One word is held while its pixels are emitted through a registered output stage. A constant alpha can be forced onto every pixel, which suits a downstream blender that needs a uniform opacity. Words with a code outside the supported set are consumed and dropped, and a sticky error flag is raised.

Top module: `pixel_unpack`

## Requirements
- R1: Code 0x0 (32-bit ARGB) yields one pixel per word, equal to the word: alpha is bits 31:24, red 23:16, green 15:8 and blue 7:0.
- R2: Code 0x1 (24-bit RGB in a 32-bit word) yields one pixel per word, with red, green and blue from bits 23:16, 15:8 and 7:0. Bits 31:24 are ignored and the alpha is 0xFF.
- R3: Code 0x4 (RGB 5-6-5) yields two pixels per word, bits 15:0 first and then bits 31:16. In each half, red is bits 15:11, green 10:5 and blue 4:0. A 5-bit channel v widens to {v, v[4:2]}, a 6-bit channel g widens to {g, g[5:4]}, and the alpha is 0xFF.
- R4: Code 0x5 (RGB 5-5-5) yields two pixels per word, low half first. In each half, red is bits 14:10, green 9:5 and blue 4:0, bit 15 is ignored, each channel widens as in R3, and the alpha is 0xFF.
- R5: Code 0xA holds bytes U (7:0), Y0 (15:8), V (23:16) and Y1 (31:24). It yields {0xFF, Y0, U, V} and then {0xFF, Y1, U, V}.
- R6: Code 0xB holds bytes V (7:0), Y0 (15:8), U (23:16) and Y1 (31:24). It yields {0xFF, Y0, U, V} and then {0xFF, Y1, U, V}.
- R7: While the override enable is high when a pixel enters the output register, that pixel's bits 31:24 equal the programmed alpha constant, whatever the format. Bits 23:0 are unchanged.
- R8: A word accepted with any other code (0x2, 0x3, 0x6 to 0x9, 0xC to 0xF) produces no pixel and sets the error flag. The flag stays set until reset.
- R9: While the output is valid and not accepted, the output data holds steady. Pixels leave in input order, with none lost or duplicated.
- R10: After reset, the output is not valid, the error flag is clear and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_fmt_i | input | 4 | Format code of the offered word |
| src_valid_i | input | 1 | Input word valid |
| src_word_i | input | 32 | Input word |
| src_ready_o | output | 1 | Input word accepted when high with valid |
| alpha_force_i | input | 1 | Replace the output alpha with the constant |
| alpha_value_i | input | 8 | Constant alpha |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_data_o | output | 32 | Output pixel {alpha, ch0, ch1, ch2} |
| pix_ready_i | input | 1 | Output pixel accepted when high with valid |
| fmt_err_o | output | 1 | Sticky unsupported-format flag |

## Verification
The bench builds the block with its default parameters: 32-bit words, 8-bit channels and 4-bit codes. That small code space lets the bench sweep every one of the 16 codes. It covers all six decoders with and without the alpha override, and all ten unsupported codes each after a fresh reset. Corner words (all zeros, all ones, single-bit channel edges) and pseudo-random words run under random output stalls. That reaches the channel widening extremes, the low-then-high ordering of two-pixel words and the stall-hold behaviour together.

// File: rtl/pixel_unpack_pkg.sv
package pixel_unpack_pkg;

  localparam int CHAN_W = 8;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    FMT_ARGB32 = 4'h0,
    FMT_RGB24  = 4'h1,
    FMT_RGB16  = 4'h4,
    FMT_RGB15  = 4'h5,
    FMT_UYVY   = 4'hA,
    FMT_VYUY   = 4'hB
  } pix_fmt_e;

  function automatic logic fmt_known(input logic [CODE_W-1:0] f);
    return (f == FMT_ARGB32) || (f == FMT_RGB24) || (f == FMT_RGB16) ||
           (f == FMT_RGB15) || (f == FMT_UYVY) || (f == FMT_VYUY);
  endfunction

  // Two pixels per word for every 16-bit-per-pixel layout
  function automatic logic fmt_dual(input logic [CODE_W-1:0] f);
    return (f == FMT_RGB16) || (f == FMT_RGB15) ||
           (f == FMT_UYVY) || (f == FMT_VYUY);
  endfunction

  function automatic logic [CHAN_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CHAN_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

endpackage

// File: rtl/pix_decode.sv
module pix_decode
  import pixel_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_W   = CHAN_W,
  parameter int FMT_W  = CODE_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic              half_i,
  output logic [WORD_W-1:0] pix_o
);

  localparam int HALF_W = WORD_W / 2;
  localparam int LANES  = WORD_W / CH_W;
  localparam logic [CH_W-1:0] OPAQUE = {CH_W{1'b1}};

  logic [LANES-1:0][CH_W-1:0] lane;
  logic [HALF_W-1:0]          sel_half;
  logic [CH_W-1:0]            luma;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[g*CH_W +: CH_W];
  end

  assign sel_half = half_i ? word_i[WORD_W-1:HALF_W] : word_i[HALF_W-1:0];
  assign luma     = half_i ? lane[3] : lane[1];

  always_comb begin
    case (fmt_i)
      FMT_ARGB32: pix_o = {lane[3], lane[2], lane[1], lane[0]};
      FMT_RGB24:  pix_o = {OPAQUE, lane[2], lane[1], lane[0]};
      FMT_RGB16:  pix_o = {OPAQUE, widen5(sel_half[15:11]),
                           widen6(sel_half[10:5]), widen5(sel_half[4:0])};
      FMT_RGB15:  pix_o = {OPAQUE, widen5(sel_half[14:10]),
                           widen5(sel_half[9:5]), widen5(sel_half[4:0])};
      FMT_UYVY:   pix_o = {OPAQUE, luma, lane[0], lane[2]};
      FMT_VYUY:   pix_o = {OPAQUE, luma, lane[2], lane[0]};
      default:    pix_o = '0;
    endcase
  end

endmodule

// File: rtl/word_hold.sv
module word_hold
  import pixel_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FMT_W  = CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic [FMT_W-1:0]  in_fmt_i,
  output logic              in_ready_o,
  input  logic              take_i,
  output logic              hold_v_o,
  output logic [WORD_W-1:0] hold_word_o,
  output logic [FMT_W-1:0]  hold_fmt_o,
  output logic              hold_half_o,
  output logic              err_o
);

  logic last_beat;
  logic accept;

  assign last_beat  = !fmt_dual(hold_fmt_o) || hold_half_o;
  assign in_ready_o = !hold_v_o || (take_i && last_beat);
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v_o    <= 1'b0;
      hold_word_o <= '0;
      hold_fmt_o  <= '0;
      hold_half_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      if (take_i) begin
        if (last_beat) hold_v_o    <= 1'b0;
        else           hold_half_o <= 1'b1;
      end
      if (accept) begin
        if (fmt_known(in_fmt_i)) begin
          hold_v_o    <= 1'b1;
          hold_word_o <= in_word_i;
          hold_fmt_o  <= in_fmt_i;
          hold_half_o <= 1'b0;
        end else begin
          err_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage #(
  parameter int WORD_W = 32,
  parameter int CH_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_v_i,
  input  logic [WORD_W-1:0] src_pix_i,
  input  logic              force_i,
  input  logic [CH_W-1:0]   force_alpha_i,
  output logic              take_o,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o,
  input  logic              out_ready_i
);

  localparam int COLOR_W = WORD_W - CH_W;

  logic load_slot;

  assign load_slot = !out_valid_o || out_ready_i;
  assign take_o    = src_v_i && load_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (load_slot) begin
      out_valid_o <= src_v_i;
      if (src_v_i) begin
        out_data_o <= force_i ? {force_alpha_i, src_pix_i[COLOR_W-1:0]} : src_pix_i;
      end
    end
  end

endmodule

// File: rtl/pixel_unpack.sv
module pixel_unpack
  import pixel_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_W   = CHAN_W,
  parameter int FMT_W  = CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FMT_W-1:0]  src_fmt_i,
  input  logic              src_valid_i,
  input  logic [WORD_W-1:0] src_word_i,
  output logic              src_ready_o,
  input  logic              alpha_force_i,
  input  logic [CH_W-1:0]   alpha_value_i,
  output logic              pix_valid_o,
  output logic [WORD_W-1:0] pix_data_o,
  input  logic              pix_ready_i,
  output logic              fmt_err_o
);

  logic              hold_v;
  logic [WORD_W-1:0] hold_word;
  logic [FMT_W-1:0]  hold_fmt;
  logic              hold_half;
  logic              take;
  logic [WORD_W-1:0] dec_pix;

  word_hold #(.WORD_W(WORD_W), .FMT_W(FMT_W)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (src_valid_i),
    .in_word_i   (src_word_i),
    .in_fmt_i    (src_fmt_i),
    .in_ready_o  (src_ready_o),
    .take_i      (take),
    .hold_v_o    (hold_v),
    .hold_word_o (hold_word),
    .hold_fmt_o  (hold_fmt),
    .hold_half_o (hold_half),
    .err_o       (fmt_err_o)
  );

  pix_decode #(.WORD_W(WORD_W), .CH_W(CH_W), .FMT_W(FMT_W)) u_dec (
    .word_i (hold_word),
    .fmt_i  (hold_fmt),
    .half_i (hold_half),
    .pix_o  (dec_pix)
  );

  pix_out_stage #(.WORD_W(WORD_W), .CH_W(CH_W)) u_out (
    .clk           (clk),
    .rst           (rst),
    .src_v_i       (hold_v),
    .src_pix_i     (dec_pix),
    .force_i       (alpha_force_i),
    .force_alpha_i (alpha_value_i),
    .take_o        (take),
    .out_valid_o   (pix_valid_o),
    .out_data_o    (pix_data_o),
    .out_ready_i   (pix_ready_i)
  );

endmodule

// File: rtl/pixel_unpack_chk.sv
module pixel_unpack_chk
  import pixel_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_W   = CHAN_W,
  parameter int FMT_W  = CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [FMT_W-1:0]  src_fmt_i,
  input logic              src_valid_i,
  input logic              src_ready_o,
  input logic              alpha_force_i,
  input logic [CH_W-1:0]   alpha_value_i,
  input logic              pix_valid_o,
  input logic [WORD_W-1:0] pix_data_o,
  input logic              pix_ready_i,
  input logic              fmt_err_o
);

  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen) begin
      AST_RESET_IDLE: assert (!pix_valid_o && !fmt_err_o && src_ready_o); // R10
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o && !pix_ready_i |=> pix_valid_o && $stable(pix_data_o)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    fmt_err_o |=> fmt_err_o); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(fmt_err_o) |-> $past(src_valid_i && src_ready_o && !fmt_known(src_fmt_i))); // R8

  AST_ALPHA_FORCED: assert property (@(posedge clk) disable iff (rst)
    $past(!pix_valid_o || pix_ready_i) && pix_valid_o && $past(alpha_force_i)
    |-> pix_data_o[WORD_W-1 -: CH_W] == $past(alpha_value_i)); // R7

endmodule

bind pixel_unpack pixel_unpack_chk #(.WORD_W(WORD_W), .CH_W(CH_W), .FMT_W(FMT_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .src_fmt_i     (src_fmt_i),
  .src_valid_i   (src_valid_i),
  .src_ready_o   (src_ready_o),
  .alpha_force_i (alpha_force_i),
  .alpha_value_i (alpha_value_i),
  .pix_valid_o   (pix_valid_o),
  .pix_data_o    (pix_data_o),
  .pix_ready_i   (pix_ready_i),
  .fmt_err_o     (fmt_err_o)
);

// File: tb/test_pixel_unpack.sv
`timescale 1ns/1ps
module test_pixel_unpack;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  fmt = 4'h0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        a_force = 1'b0;
  logic [7:0]  a_value = 8'h00;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b0;
  logic        err;

  int n_cmp = 0;
  int n_bad = 0;
  int bp_pct = 40;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  always #2.5 clk = ~clk;

  pixel_unpack i_pixel_unpack (
    .clk(clk), .rst(rst), .src_fmt_i(fmt), .src_valid_i(in_valid),
    .src_word_i(in_data), .src_ready_o(in_ready), .alpha_force_i(a_force),
    .alpha_value_i(a_value), .pix_valid_o(out_valid), .pix_data_o(out_data),
    .pix_ready_i(out_ready), .fmt_err_o(err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] grow5(input logic [4:0] v);
    int x = int'(v);
    return 8'(x * 8 + x / 4);
  endfunction

  function automatic logic [7:0] grow6(input logic [5:0] v);
    int x = int'(v);
    return 8'(x * 4 + x / 16);
  endfunction

  function automatic bit is_known(input logic [3:0] f);
    return f inside {4'h0, 4'h1, 4'h4, 4'h5, 4'hA, 4'hB};
  endfunction

  function automatic int beats(input logic [3:0] f);
    return (f inside {4'h4, 4'h5, 4'hA, 4'hB}) ? 2 : 1;
  endfunction

  function automatic logic [31:0] model(input logic [3:0] f, input logic [31:0] w,
                                        input int h, input bit fo, input logic [7:0] fa);
    logic [15:0] s;
    logic [31:0] p;
    s = (h != 0) ? w[31:16] : w[15:0];
    case (f)
      4'h0: p = w;                                                       // R1
      4'h1: p = {8'hFF, w[23:0]};                                        // R2
      4'h4: p = {8'hFF, grow5(s[15:11]), grow6(s[10:5]), grow5(s[4:0])}; // R3
      4'h5: p = {8'hFF, grow5(s[14:10]), grow5(s[9:5]), grow5(s[4:0])};  // R4
      4'hA: p = {8'hFF, (h != 0) ? w[31:24] : w[15:8], w[7:0], w[23:16]};   // R5
      default: p = {8'hFF, (h != 0) ? w[31:24] : w[15:8], w[23:16], w[7:0]}; // R6
    endcase
    if (fo) p[31:24] = fa;                                               // R7
    return p;
  endfunction

  function automatic string fmt_tag(input logic [3:0] f, input bit fo);
    if (fo) return "R7";
    case (f)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h4: return "R3";
      4'h5: return "R4";
      4'hA: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) out_ready = ($urandom % 100) >= bp_pct;

  // Output monitor: handshake completes at the next rising edge
  always @(negedge clk) begin
    #1;
    if (rst) begin
      prev_stall = 1'b0;
    end else begin
      if (prev_stall) check(out_valid && out_data == prev_data, "R9 stall hold", out_data, prev_data);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8/R9 unexpected pixel", out_data, 32'h0);
        end else begin
          check(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic send_word(input logic [3:0] f, input logic [31:0] w);
    bit acc;
    if (is_known(f)) begin
      for (int h = 0; h < beats(f); h++) begin
        exp_q.push_back(model(f, w, h, a_force, a_value));
        tag_q.push_back(fmt_tag(f, a_force));
      end
    end
    @(negedge clk);
    in_valid = 1'b1;
    fmt      = f;
    in_data  = w;
    while (1) begin
      #1;
      acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    exp_q.delete();
    tag_q.delete();
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R10 reset valid", {31'h0, out_valid}, 32'h0);
    check(!err, "R10 reset error flag", {31'h0, err}, 32'h0);
    check(in_ready, "R10 reset ready", {31'h0, in_ready}, 32'h1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] good[6] = '{4'h0, 4'h1, 4'h4, 4'h5, 4'hA, 4'hB};
    logic [3:0] bad[10] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF};
    logic [31:0] corner[6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_8000,
                               32'h7FFF_7FFF, 32'h0821_F7DE, 32'h1234_ABCD};
    do_reset();

    for (int gi = 0; gi < 6; gi++) begin
      for (int fo = 0; fo < 2; fo++) begin
        a_force = fo[0];
        a_value = 8'h5A ^ {4'h0, good[gi]};
        bp_pct  = (gi % 2 == 0) ? 40 : 10;
        for (int c = 0; c < 6; c++) send_word(good[gi], corner[c]);
        for (int k = 0; k < 150; k++) send_word(good[gi], $urandom);
        drain();
        #1;
        check(!err, "R8 no error on valid code", {31'h0, err}, 32'h0);
      end
    end
    a_force = 1'b0;

    for (int bi = 0; bi < 10; bi++) begin
      do_reset();
      send_word(bad[bi], 32'hDEAD_BEEF);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(err, "R8 error raised", {31'h0, err}, 32'h1);
      check(!out_valid, "R8 no pixel from bad code", {31'h0, out_valid}, 32'h0);
      send_word(4'h0, 32'h1122_3344 + bi);
      drain();
      #1;
      check(err, "R8 error sticky", {31'h0, err}, 32'h1);
    end
    do_reset();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule